// File: doc/BRIEF.md
# Step-Adaptive Post-Decimation Filter

This block is the second filtering stage of a sigma-delta measurement converter. It sits behind a sinc3 decimator and takes one signed 24-bit sample at a time, each marked by a valid strobe. For each sample it returns one filtered signed 24-bit word with its own valid strobe, one clock later.

In its normal state the block runs a symmetric 22-tap low-pass FIR with unity DC gain. A bypass control copies each incoming sample straight to the output. When the fast-settle control is on, a jump in the input larger than a programmable threshold starts a moving average. The average grows by one sample per input, up to 16. This gives a usable estimate of the new level at once, and the estimate gets less noisy as the window grows. Once 22 post-jump samples have filled the FIR delay line, the block goes back to FIR output on its own. So the time to reach full noise performance is the same as with the fast-settle control off.

Top module: `step_avg_filter`

## Requirements
- R1: Every cycle with `inValid` high produces exactly one output word, with `outValid` high for one cycle on the next clock. `outValid` is low, and `outData` keeps its value, after any cycle without `inValid`.
- R2: While `bypassEn` is 1, each output word equals the input sample that produced it, including the extreme codes -8388608 and 8388607.
- R3: In FIR mode, the output for the newest sample x[0] is (sum of h[i]*x[i], plus 65536) shifted arithmetically right by 17, then saturated to signed 24 bits. x[i] is the sample i inputs before x[0]. The coefficients are h[i] = h[21-i] = (i+1)*1000 for i = 0..9, and h[10] = h[11] = 10536.
- R4: With `fastEn` at 0, a jump from one constant level to another first appears exactly at the output on the 22nd output word after the jump, and not on the 21st.
- R5: A jump is detected only when `fastEn` is 1, `bypassEn` is 0, and |sample - last output word| is strictly greater than `stepThr` (unsigned). A difference equal to `stepThr` leaves the block in FIR mode.
- R6: In averaging mode, the k-th sample after detection (k = 1..21) produces the mean of the newest min(k,16) post-jump samples. The mean is rounded to the nearest integer, with ties rounded away from zero.
- R7: The 22nd post-jump sample and all later ones produce FIR output again (as in R3), computed only from post-jump samples.
- R8: A new detection during averaging restarts the window at k = 1 from the sample that triggered it.
- R9: After reset, `outValid` is 0 and `outData` is 0.
- R10: With `fastEn` at 1, the first output word after a detected jump equals the triggering sample, so a clean step settles within one output word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | First-stage sample strobe |
| inData | input | 24 | First-stage sample, signed |
| fastEn | input | 1 | Enables jump detection and averaging |
| bypassEn | input | 1 | Passes samples through unfiltered |
| stepThr | input | 24 | Jump detection threshold, unsigned |
| outValid | output | 1 | Output word strobe |
| outData | output | 24 | Filtered output word, signed |

## Verification
The properties assume that `fastEn`, `bypassEn` and `stepThr` are quasi-static: they change only between samples, never in the cycle in which a sample is accepted. The properties also assume that `inValid` is low while reset is held. The stimulus changes the controls only between sample tasks and holds `inValid` low during reset. It spaces the samples two clocks apart, so every output word is sampled in isolation. A running model of the requirements predicts every word, including the noisy averages and the handover back to FIR.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
  localparam int DATA_W  = 24;
  localparam int COEF_W  = 18;
  localparam int TAPS    = 22;
  localparam int FRAC    = 17;
  localparam int MAX_WIN = 16;
  localparam int CNT_W   = $clog2(TAPS + 1);
  localparam int WIN_W   = $clog2(MAX_WIN + 1);

  typedef struct packed {
    logic             shift;
    logic             flush;
    logic             selAvg;
    logic             selBypass;
    logic [WIN_W-1:0] winLen;
  } sdf_strobe_t;

  // Symmetric linear ramp; the two centre taps absorb the remainder so
  // that the coefficients sum to 2**frac (unity DC gain).
  function automatic int firCoef(int idx, int taps, int frac);
    int half;
    int j;
    int rest;
    half = taps / 2;
    j    = (idx < half) ? idx : taps - 1 - idx;
    rest = (1 << (frac - 1));
    for (int k = 0; k < half - 1; k++) rest -= (k + 1) * 1000;
    return (j < half - 1) ? (j + 1) * 1000 : rest;
  endfunction
endpackage

// File: rtl/sdf_ctrl.sv
module sdf_ctrl
  import sdf_pkg::*;
#(
  parameter int NT = TAPS,
  parameter int MW = MAX_WIN
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        fastEn,
  input  logic        bypassEn,
  input  logic        bigStep,
  output sdf_strobe_t strb,
  output logic        outValid
);
  typedef enum logic {MODE_FIR, MODE_AVG} mode_e;

  mode_e            mode;
  logic [CNT_W-1:0] postCnt;
  logic [CNT_W-1:0] nextCnt;
  logic             trig;
  logic             stayAvg;

  always_comb begin
    trig    = fastEn & ~bypassEn & bigStep;
    nextCnt = trig ? CNT_W'(1) : postCnt + CNT_W'(1);
    stayAvg = (mode == MODE_AVG) & fastEn & ~bypassEn & (nextCnt < CNT_W'(NT));
    strb.shift     = inValid;
    strb.flush     = trig;
    strb.selBypass = bypassEn;
    strb.selAvg    = trig | stayAvg;
    strb.winLen    = (nextCnt > CNT_W'(MW)) ? WIN_W'(MW) : WIN_W'(nextCnt);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode     <= MODE_FIR;
      postCnt  <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        if (trig | stayAvg) begin
          mode    <= MODE_AVG;
          postCnt <= nextCnt;
        end else begin
          mode    <= MODE_FIR;
          postCnt <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/sdf_datapath.sv
module sdf_datapath
  import sdf_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = COEF_W,
  parameter int NT = TAPS,
  parameter int FB = FRAC,
  parameter int MW = MAX_WIN
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  sdf_strobe_t          strb,
  input  logic signed [DW-1:0] inData,
  input  logic        [DW-1:0] stepThr,
  output logic                 bigStep,
  output logic signed [DW-1:0] outData
);
  localparam int HALF  = NT / 2;
  localparam int ACC_W = DW + CW + $clog2(NT) + 1;
  localparam int SUM_W = DW + $clog2(MW) + 1;
  localparam logic signed [ACC_W-1:0] OUT_MAX = ACC_W'((64'sd1 <<< (DW - 1)) - 64'sd1);
  localparam logic signed [ACC_W-1:0] OUT_MIN = -OUT_MAX - ACC_W'(1);
  localparam logic signed [ACC_W-1:0] RND     = ACC_W'(64'sd1 <<< (FB - 1));

  logic signed [DW-1:0]    dly  [NT-1];
  logic signed [DW-1:0]    tapW [NT];
  logic signed [ACC_W-1:0] prod [HALF];

  always_comb begin
    tapW[0] = inData;
    for (int i = 1; i < NT; i++) tapW[i] = dly[i-1];
  end

  // Symmetric folding: one multiplier per coefficient pair.
  for (genvar g = 0; g < HALF; g++) begin : g_pair
    localparam logic signed [CW-1:0] K = CW'(firCoef(g, NT, FB));
    logic signed [DW:0] pairSum;
    assign pairSum = (DW+1)'(tapW[g]) + (DW+1)'(tapW[NT-1-g]);
    assign prod[g] = ACC_W'(pairSum) * ACC_W'(K);
  end

  logic signed [ACC_W-1:0] firAcc;
  logic signed [ACC_W-1:0] firShr;
  logic signed [DW-1:0]    firOut;

  always_comb begin
    firAcc = '0;
    for (int i = 0; i < HALF; i++) firAcc += prod[i];
    firShr = (firAcc + RND) >>> FB;
    if (firShr > OUT_MAX)      firOut = DW'(OUT_MAX);
    else if (firShr < OUT_MIN) firOut = DW'(OUT_MIN);
    else                       firOut = DW'(firShr);
  end

  logic signed [SUM_W-1:0] winSum;
  logic        [SUM_W-1:0] winMag;
  logic        [SUM_W-1:0] winDiv;
  logic        [SUM_W-1:0] winQuo;
  logic signed [DW-1:0]    avgOut;

  always_comb begin
    winSum = '0;
    for (int i = 0; i < MW; i++)
      if (WIN_W'(i) < strb.winLen) winSum += SUM_W'(tapW[i]);
    winMag = winSum[SUM_W-1] ? SUM_W'(-winSum) : SUM_W'(winSum);
    winDiv = (strb.winLen == '0) ? SUM_W'(1) : SUM_W'(strb.winLen);
    winQuo = (winMag + (winDiv >> 1)) / winDiv;
    avgOut = winSum[SUM_W-1] ? DW'(-winQuo) : DW'(winQuo);
  end

  logic signed [DW:0] gap;
  logic        [DW:0] gapMag;

  always_comb begin
    gap     = (DW+1)'(inData) - (DW+1)'(outData);
    gapMag  = gap[DW] ? (DW+1)'(-gap) : (DW+1)'(gap);
    bigStep = gapMag > {1'b0, stepThr};
  end

  logic signed [DW-1:0] nextOut;
  assign nextOut = strb.selBypass ? inData : (strb.selAvg ? avgOut : firOut);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outData <= '0;
      for (int i = 0; i < NT - 1; i++) dly[i] <= '0;
    end else if (strb.shift) begin
      outData <= nextOut;
      dly[0]  <= inData;
      for (int i = 1; i < NT - 1; i++) dly[i] <= strb.flush ? '0 : dly[i-1];
    end
  end
endmodule

// File: rtl/step_avg_filter.sv
module step_avg_filter
  import sdf_pkg::*;
#(
  parameter int DATA_W_P = DATA_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [DATA_W_P-1:0] inData,
  input  logic                fastEn,
  input  logic                bypassEn,
  input  logic [DATA_W_P-1:0] stepThr,
  output logic                outValid,
  output logic [DATA_W_P-1:0] outData
);
  sdf_strobe_t                strb;
  logic                       bigStep;
  logic signed [DATA_W_P-1:0] outWord;

  sdf_ctrl #(.NT(TAPS), .MW(MAX_WIN)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .fastEn(fastEn),
    .bypassEn(bypassEn), .bigStep(bigStep), .strb(strb), .outValid(outValid)
  );

  sdf_datapath #(.DW(DATA_W_P), .CW(COEF_W), .NT(TAPS), .FB(FRAC), .MW(MAX_WIN)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inData(inData),
    .stepThr(stepThr), .bigStep(bigStep), .outData(outWord)
  );

  assign outData = outWord;
endmodule

// File: rtl/sdf_checker.sv
module sdf_checker #(
  parameter int DW = 24
) (
  input logic          clk,
  input logic          rstN,
  input logic          inValid,
  input logic [DW-1:0] inData,
  input logic          fastEn,
  input logic          bypassEn,
  input logic [DW-1:0] stepThr,
  input logic          outValid,
  input logic [DW-1:0] outData
);
  logic signed [DW:0] jump;
  logic        [DW:0] jumpMag;

  always_comb begin
    jump    = (DW+1)'($signed(inData)) - (DW+1)'($signed(outData));
    jumpMag = jump[DW] ? (DW+1)'(-jump) : (DW+1)'(jump);
  end

  assert_word_follows_R1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  assert_hold_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(outData));

  assert_bypass_copy_R2: assert property (@(posedge clk) disable iff (!rstN)
    inValid && bypassEn |=> outData == $past(inData));

  assert_jump_settles_R10: assert property (@(posedge clk) disable iff (!rstN)
    inValid && fastEn && !bypassEn && (jumpMag > {1'b0, stepThr})
      |=> outData == $past(inData));
endmodule

bind step_avg_filter sdf_checker #(.DW(DATA_W_P)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
  .fastEn(fastEn), .bypassEn(bypassEn), .stepThr(stepThr),
  .outValid(outValid), .outData(outData)
);

// File: tb/step_avg_filter_tb.sv
`timescale 1ns/1ps
module step_avg_filter_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [23:0] inData = '0;
  logic        fastEn = 1'b0;
  logic        bypassEn = 1'b0;
  logic [23:0] stepThr = '0;
  logic        outValid;
  logic [23:0] outData;

  int  nTests = 0;
  int  nFail = 0;
  bit  done = 0;
  int  seed = 7;

  longint hist [22];
  bit     mAvg = 0;
  int     mCnt = 0;
  longint mLast = 0;

  always #2 clk = ~clk;

  step_avg_filter u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .fastEn(fastEn), .bypassEn(bypassEn), .stepThr(stepThr),
    .outValid(outValid), .outData(outData)
  );

  function automatic longint kc(int i);
    int j;
    j = (i < 11) ? i : 21 - i;
    return (j < 10) ? longint'((j + 1) * 1000) : 64'sd10536;
  endfunction

  function automatic longint modelStep(longint x);
    longint d, acc, r, s, m, q;
    int n;
    d = x - mLast;
    if (d < 0) d = -d;
    if (bypassEn) begin
      for (int i = 21; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = x; mAvg = 0; mCnt = 0; r = x;
    end else if (fastEn && d > longint'(stepThr)) begin
      for (int i = 0; i < 22; i++) hist[i] = 0;
      hist[0] = x; mAvg = 1; mCnt = 1; r = x;
    end else begin
      for (int i = 21; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = x;
      if (mAvg && fastEn && mCnt + 1 < 22) begin
        mCnt++;
        n = (mCnt > 16) ? 16 : mCnt;
        s = 0;
        for (int i = 0; i < n; i++) s += hist[i];
        m = (s < 0) ? -s : s;
        q = (m + n / 2) / n;
        r = (s < 0) ? -q : q;
      end else begin
        mAvg = 0; mCnt = 0; acc = 0;
        for (int i = 0; i < 22; i++) acc += kc(i) * hist[i];
        r = (acc + 65536) >>> 17;
        if (r > 8388607) r = 8388607;
        if (r < -8388608) r = -8388608;
      end
    end
    mLast = r;
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(input longint x, input string tag, output longint act);
    longint exp;
    @(negedge clk);
    inValid = 1'b1;
    inData  = 24'(x);
    exp     = modelStep(x);
    @(negedge clk);
    inValid = 1'b0;
    act = longint'($signed(outData));
    check(outValid === 1'b1, {tag, " valid (R1)"}, longint'(outValid), 1);
    check(act == exp, tag, act, exp);
  endtask

  function automatic longint noise(int span);
    seed = seed * 1103515245 + 12345;
    return longint'((seed >>> 8) % span);
  endfunction

  task automatic testReset;
    check(outValid === 1'b0, "R9 valid", longint'(outValid), 0);
    check(outData === 24'd0, "R9 data", longint'(outData), 0);
  endtask

  task automatic testFirImpulse;
    longint a;
    fastEn = 0; bypassEn = 0;
    for (int i = 0; i < 22; i++) send(0, "R3 zero", a);
    send(100000, "R3 impulse", a);
    check(a == 763, "R3 first impulse word", a, 763);
    for (int i = 0; i < 21; i++) send(0, "R3 tail", a);
  endtask

  task automatic testFirMixed;
    longint a;
    for (int i = 0; i < 30; i++) send(noise(8388607), "R3 mixed", a);
  endtask

  task automatic testSlowStep;
    longint a;
    for (int i = 0; i < 25; i++) send(1000, "R4 base", a);
    for (int k = 1; k <= 23; k++) begin
      send(500000, "R4 step", a);
      if (k == 21) check(a != 500000, "R4 not yet at 21", a, 500000);
      if (k == 22) check(a == 500000, "R4 settled at 22", a, 500000);
    end
  endtask

  task automatic testBypass;
    longint a;
    bypassEn = 1;
    send(-8388608, "R2 min", a);
    check(a == -8388608, "R2 min copy", a, -8388608);
    send(8388607, "R2 max", a);
    check(a == 8388607, "R2 max copy", a, 8388607);
    for (int i = 0; i < 6; i++) send(noise(3000000), "R2 copy", a);
    bypassEn = 0;
  endtask

  task automatic testThreshold;
    longint a;
    fastEn = 1; stepThr = 24'd1000;
    for (int i = 0; i < 30; i++) send(5000, "R5 base", a);
    send(6000, "R5 equal thr", a);
    check(a != 6000, "R5 no detect at equal", a, 6000);
    send(40000, "R10 detect", a);
    check(a == 40000, "R10 first word", a, 40000);
  endtask

  task automatic testFastStep;
    longint a;
    stepThr = 24'd100000;
    for (int i = 0; i < 30; i++) send(0, "R6 base", a);
    send(1000000, "R10 step", a);
    check(a == 1000000, "R10 step word", a, 1000000);
    send(1000001, "R6 tie", a);
    check(a == 1000001, "R6 tie away", a, 1000001);
    for (int k = 3; k <= 26; k++)
      send(1000000 + noise(100), (k >= 22) ? "R7 fir return" : "R6 growing avg", a);
    send(-1000000, "R10 neg step", a);
    send(-1000001, "R6 neg tie", a);
    check(a == -1000001, "R6 neg tie away", a, -1000001);
  endtask

  task automatic testRetrigger;
    longint a;
    for (int i = 0; i < 3; i++) send(-1000000 + noise(50), "R8 pre", a);
    send(200000, "R8 retrigger", a);
    check(a == 200000, "R8 restart word", a, 200000);
    send(200002, "R8 window two", a);
    check(a == 200001, "R8 two-sample mean", a, 200001);
    for (int i = 0; i < 22; i++) send(200000 + noise(40), "R8 after", a);
  endtask

  initial begin
    for (int i = 0; i < 22; i++) hist[i] = 0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testFirImpulse();
    testFirMixed();
    testSlowStep();
    testBypass();
    testThreshold();
    testFastStep();
    testRetrigger();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule